// File: doc/BRIEF.md
# Symbol Serializer with Three-Level Line Encoder

This block sits at the transmit edge of a 100 Mb/s copper physical layer, between the coding sublayer that produces 5-bit code groups and the analog line driver. It runs entirely on the fast bit clock. From that clock it makes its own symbol clock at one fifth of the rate and sends it upstream. The coding layer presents one code group per symbol clock period. The block captures each group and shifts it out one bit per bit clock. It turns the serial stream into NRZI and maps the NRZI transitions onto a three-level MLT-3 output code.

Two control inputs gate the drive. The output-enable input switches the line drive off whatever else is set. The loopback input also switches the line drive off. In loopback the NRZI serial stream is routed to a separate output so that the receive side can take it in place of the line signal.

Top module: `mlt3_serializer`

## Requirements
- R1: `symClk` is a registered divide-by-five of `clk`. It is high for 2 bit clocks and then low for 3. After reset it starts in the first of its two high cycles.
- R2: `symData` is captured into a holding register at the bit clock edge where `symClk` rises. The holding register is copied into the shifter at the next such edge. It is not copied at the edge that captures it.
- R3: The shifter sends bit 0 of each code group first and bit 4 last, one bit per bit clock.
- R4: The NRZI level toggles at each bit clock whose serial bit is 1 and holds when that bit is 0.
- R5: On each serial 1, the line level steps through the cycle 0 (heading positive), +1, 0 (heading negative), -1. On each serial 0 it holds. `lineLevel` encodes +1 as 2'b01, 0 as 2'b00 and -1 as 2'b11. It never takes the value 2'b10.
- R6: Reset leaves the NRZI level at 0, the line state at zero heading positive, and the holding register and shifter at all zeros. So the first ten bit clocks after reset send zeros.
- R7: When `txEnable` is low, `driveEn` is low, whatever the level of `loopEnable`.
- R8: When `loopEnable` is high, `driveEn` is low and `loopNrzi` follows the NRZI level. When `loopEnable` is low, `loopNrzi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (serial rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| symData | input | 5 | Code group from the coding layer |
| txEnable | input | 1 | Line drive permitted when high |
| loopEnable | input | 1 | Loopback select |
| symClk | output | 1 | Divide-by-five symbol clock toward the coding layer |
| lineLevel | output | 2 | Three-level line code: 01 = +1, 00 = 0, 11 = -1 |
| driveEn | output | 1 | Line driver enable |
| loopNrzi | output | 1 | NRZI stream for the receive path during loopback |

## Verification
A code group presented before the edge where `symClk` rises (call it edge E) first affects `lineLevel` just after edge E+6. Edge E captures the group, edge E+5 loads it into the shifter, and edge E+6 folds bit 0 into the NRZI and line state. The remaining bits follow on one edge each. `symClk` changes on the edge that advances the phase counter. `driveEn` and `loopNrzi` follow the control inputs within the same cycle. The bench model moves its own phase count and queue of pending bits on every rising edge. It compares all four outputs at the following falling edge and changes inputs only after that comparison, so each result is sampled in the cycle it is due.

// File: rtl/mlt3_pkg.sv
package mlt3_pkg;

  // Strobes the control module sends to the datapath
  typedef struct packed {
    logic loadHold;   // capture upstream code group
    logic loadShift;  // move holding register into shifter
  } txStrobes_t;

  // Four-step line state; stepping happens on each serial one
  typedef enum logic [1:0] {
    MLT_ZERO_UP = 2'd0,
    MLT_POS     = 2'd1,
    MLT_ZERO_DN = 2'd2,
    MLT_NEG     = 2'd3
  } mltState_t;

  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_NEG  = 2'b11;

endpackage

// File: rtl/mlt3_ctl.sv
module mlt3_ctl
  import mlt3_pkg::*;
#(
  parameter int SYM_W    = 5,
  parameter int CLK_HIGH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  output txStrobes_t strobes,
  output logic       symClk
);

  localparam int CNT_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(SYM_W - 1);
  localparam logic [CNT_W-1:0] HIGH_PH = CNT_W'(CLK_HIGH);

  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] phaseNext;
  logic             wrapNow;

  assign wrapNow   = (phase == LAST_PH);
  assign phaseNext = wrapNow ? '0 : phase + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      symClk <= 1'b1;
    end else begin
      phase  <= phaseNext;
      symClk <= (phaseNext < HIGH_PH);
    end
  end

  // Capture and shifter load share the wrap edge: the shifter takes the
  // previous word while the holding register takes the new one.
  always_comb begin
    strobes.loadHold  = wrapNow;
    strobes.loadShift = wrapNow;
  end

endmodule

// File: rtl/mlt3_dp.sv
module mlt3_dp
  import mlt3_pkg::*;
#(
  parameter int SYM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  txStrobes_t       strobes,
  input  logic [SYM_W-1:0] symData,
  output logic             serialBit,
  output logic             nrziLevel,
  output logic [1:0]       lineLevel
);

  logic [SYM_W-1:0] holdReg;
  logic [SYM_W-1:0] shiftReg;
  mltState_t        mltState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg <= '0;
    end else if (strobes.loadHold) begin
      holdReg <= symData;
    end
  end

  // Parallel-in serial-out, least significant bit leaves first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg <= '0;
    end else if (strobes.loadShift) begin
      shiftReg <= holdReg;
    end else begin
      shiftReg <= {1'b0, shiftReg[SYM_W-1:1]};
    end
  end

  assign serialBit = shiftReg[0];

  // Last stage: NRZ to NRZI, followed by the three-level stepper
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nrziLevel <= 1'b0;
      mltState  <= MLT_ZERO_UP;
    end else if (serialBit) begin
      nrziLevel <= ~nrziLevel;
      mltState  <= mltState_t'(mltState + 2'd1);
    end
  end

  always_comb begin
    unique case (mltState)
      MLT_POS: lineLevel = LVL_POS;
      MLT_NEG: lineLevel = LVL_NEG;
      default: lineLevel = LVL_ZERO;
    endcase
  end

endmodule

// File: rtl/mlt3_serializer.sv
module mlt3_serializer
  import mlt3_pkg::*;
#(
  parameter int SYM_W    = 5,
  parameter int CLK_HIGH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] symData,
  input  logic             txEnable,
  input  logic             loopEnable,
  output logic             symClk,
  output logic [1:0]       lineLevel,
  output logic             driveEn,
  output logic             loopNrzi
);

  txStrobes_t strobes;
  logic       serialBit;
  logic       nrziLevel;

  mlt3_ctl #(
    .SYM_W   (SYM_W),
    .CLK_HIGH(CLK_HIGH)
  ) u_ctl (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .symClk (symClk)
  );

  mlt3_dp #(
    .SYM_W(SYM_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .symData  (symData),
    .serialBit(serialBit),
    .nrziLevel(nrziLevel),
    .lineLevel(lineLevel)
  );

  assign driveEn  = txEnable & ~loopEnable;
  assign loopNrzi = loopEnable & nrziLevel;

endmodule

// File: rtl/mlt3_serializer_chk.sv
module mlt3_serializer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       symClk,
  input logic [1:0] lineLevel,
  input logic       driveEn,
  input logic       txEnable,
  input logic       loopEnable,
  input logic       serialBit,
  input logic       nrziLevel,
  input logic       loopNrzi
);

  // R1: high phase lasts two cycles, low phase three
  assert_clk_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(symClk) |=> symClk);
  assert_clk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(symClk) |=> !symClk ##1 !symClk);

  // R4: NRZI toggles on a one, holds on a zero
  assert_nrzi_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    serialBit |=> (nrziLevel != $past(nrziLevel)));
  assert_nrzi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !serialBit |=> $stable(nrziLevel));

  // R5: level holds on a zero and never takes the unused code
  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !serialBit |=> $stable(lineLevel));
  assert_level_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lineLevel != 2'b10);

  // R7: output enable low forces drive off
  assert_txoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |-> !driveEn);

  // R8: loopback disables drive and exposes the NRZI stream
  assert_loop_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loopEnable |-> (!driveEn && (loopNrzi == nrziLevel)));
  assert_loop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !loopEnable |-> !loopNrzi);

endmodule

bind mlt3_serializer mlt3_serializer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .symClk    (symClk),
  .lineLevel (lineLevel),
  .driveEn   (driveEn),
  .txEnable  (txEnable),
  .loopEnable(loopEnable),
  .serialBit (serialBit),
  .nrziLevel (nrziLevel),
  .loopNrzi  (loopNrzi)
);

// File: tb/mlt3_serializer_bench.sv
`timescale 1ns/1ps
module mlt3_serializer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] symData = '0;
  logic       txEnable = 1'b1;
  logic       loopEnable = 1'b0;
  logic       symClk;
  logic [1:0] lineLevel;
  logic       driveEn;
  logic       loopNrzi;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mlt3_serializer u_mlt3_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .symData   (symData),
    .txEnable  (txEnable),
    .loopEnable(loopEnable),
    .symClk    (symClk),
    .lineLevel (lineLevel),
    .driveEn   (driveEn),
    .loopNrzi  (loopNrzi)
  );

  // Behavioural reference state
  int         phaseM;
  bit         bitQ[$];
  logic [4:0] holdM;
  bit         nrziM;
  int         stepM;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int levelOf(input int step);
    if (step == 1) return 1;        // 2'b01
    if (step == 3) return 3;        // 2'b11
    return 0;
  endfunction

  function automatic logic [4:0] pattern(input int cyc);
    logic [4:0] fixed [8] = '{5'h1F, 5'h00, 5'h15, 5'h0A, 5'h01, 5'h10, 5'h1F, 5'h03};
    if (cyc < 40) return fixed[cyc / 5];
    return 5'($urandom);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    bit front;
    repeat (3) @(negedge clk);
    // R6 / R1: reset state
    check("R6 lineLevel", int'(lineLevel), 0);
    check("R1 symClk reset", int'(symClk), 1);
    check("R8 loopNrzi reset", int'(loopNrzi), 0);

    phaseM = 0;
    holdM  = '0;
    nrziM  = 0;
    stepM  = 0;
    for (int k = 0; k < 5; k++) bitQ.push_back(1'b0);
    symData = pattern(0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < 600; cyc++) begin
      @(posedge clk);
      front = bitQ.pop_front();
      if (front) begin
        nrziM = ~nrziM;
        stepM = (stepM + 1) % 4;
      end
      if (phaseM == 4) begin
        for (int b = 0; b < 5; b++) bitQ.push_back(holdM[b]);
        holdM = symData;
      end
      phaseM = (phaseM + 1) % 5;

      @(negedge clk);
      check("R1 symClk", int'(symClk), (phaseM < 2) ? 1 : 0);
      check("R2/R3/R5/R6 lineLevel", int'(lineLevel), levelOf(stepM));
      check("R7/R8 driveEn", int'(driveEn), (txEnable && !loopEnable) ? 1 : 0);
      check("R4/R8 loopNrzi", int'(loopNrzi), loopEnable ? int'(nrziM) : 0);

      symData    = pattern(cyc + 1);
      txEnable   = !((cyc >= 100 && cyc < 130) || (cyc >= 220 && cyc < 240));
      loopEnable = (cyc >= 150 && cyc < 200) || (cyc >= 230 && cyc < 260);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule